// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two unsigned operands one bit position per clock cycle. A start pulse copies both operands into two right-shifting registers and clears a single carry flip-flop. On each following cycle, one full adder combines the low bits of both registers with the stored carry. The sum bit enters the first register at its top end, and the carry out is stored for the next position.

After one cycle per bit, the first register holds the sum bits and the carry flip-flop holds the final carry. The block then raises a one-cycle completion pulse. The result stays on the sum output until the next accepted start. A start that arrives while an addition is in progress is ignored. The block suits places where adder area matters more than latency.

Top module: `serial_adder`

## Requirements
- R1: After reset, `sum` is 0 and both `busy` and `done` are 0.
- R2: A `start` sampled high while `busy` is 0 loads the operands and clears the carry. In the next cycle, `busy` is 1 and `sum` equals {1'b0, `op_a`}.
- R3: Exactly WIDTH shift cycles follow a load. `busy` stays high for WIDTH cycles, and `done` rises in the cycle in which `busy` falls.
- R4: When `done` is high, `sum` equals `op_a + op_b` as a (WIDTH+1)-bit value. The carry out of the top bit is in bit WIDTH.
- R5: Addition starts at the least significant bit. After the first shift cycle, `sum` is {c0, s0, `op_a`[WIDTH-1:1]}, where s0 is `op_a`[0] XOR `op_b`[0] and c0 is `op_a`[0] AND `op_b`[0].
- R6: A `start` sampled while `busy` is 1 has no effect: the result is still the sum of the operands loaded first, and the cycle count is unchanged.
- R7: When idle with no `start`, `sum` holds its value.
- R8: `done` is high for exactly one cycle per addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins an addition when idle |
| op_a | input | WIDTH | First operand, loaded on start |
| op_b | input | WIDTH | Second operand, loaded on start |
| busy | output | 1 | High while shift cycles are in progress |
| done | output | 1 | One-cycle pulse when the sum is complete |
| sum | output | WIDTH+1 | {carry flip-flop, A register} |

## Verification
The loaded operand appears on `sum` one cycle after the start edge. The first partial sum appears one cycle after that. The complete result and `done` appear WIDTH cycles after the load edge. The bench drives inputs on the falling edge and samples on the falling edge that follows each of these rising edges. It walks through every cycle of each addition, checking `busy` and `done` at each step, so both early and late completion are caught. After `done`, one further cycle checks that the pulse has ended and that the result holds.

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             busy,
  output logic             done,
  output logic [WIDTH:0]   sum
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [WIDTH-1:0] a_q, b_q;
  logic             c_q, busy_q, done_q;
  logic [CW-1:0]    cnt_q;

  logic fa_s, fa_co, accept, last;

  assign fa_s   = a_q[0] ^ b_q[0] ^ c_q;
  assign fa_co  = (a_q[0] & b_q[0]) | (c_q & (a_q[0] ^ b_q[0]));
  assign accept = start && !busy_q;
  assign last   = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= 1'b0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        a_q    <= op_a;
        b_q    <= op_b;
        c_q    <= 1'b0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        a_q   <= {fa_s, a_q[WIDTH-1:1]};
        b_q   <= {1'b0, b_q[WIDTH-1:1]};
        c_q   <= fa_co;
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign sum  = {c_q, a_q};

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && sum == {1'b0, $past(op_a)}));

  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(sum));

  a_r6_busy_keeps_going: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> (busy || done));
endmodule

// File: tb/serial_adder_bench.sv
module serial_adder_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         busy, done;
  logic [W:0]   sum;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  serial_adder #(.WIDTH(W)) u_serial_adder (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .sum(sum)
  );

  function automatic logic [W:0] exp_sum(logic [W-1:0] a, logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [W:0] exp_first(logic [W-1:0] a, logic [W-1:0] b);
    return {a[0] & b[0], a[0] ^ b[0], a[W-1:1]};
  endfunction

  task automatic chk(bit ok, string req, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_add(logic [W-1:0] a, logic [W-1:0] b, bit intrude);
    logic [W:0] res;
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R2 busy", {4'b0, busy}, 1);
    chk(sum === {1'b0, a}, "R2 load", sum, {1'b0, a});
    for (int k = 1; k <= W; k++) begin
      if (intrude && k == 1) begin
        start = 1'b1; op_a = ~a; op_b = a;
      end
      @(negedge clk);
      start = 1'b0;
      if (k == 1 && W > 1) chk(sum === exp_first(a, b), "R5 lsb first", sum, exp_first(a, b));
      if (k < W) chk(busy === 1'b1 && done === 1'b0, "R3 still busy", {3'b0, busy, done}, 2);
      else begin
        chk(busy === 1'b0 && done === 1'b1, "R3 done at W", {3'b0, busy, done}, 1);
        chk(sum === exp_sum(a, b), intrude ? "R6 R4 result" : "R4 result", sum, exp_sum(a, b));
      end
    end
    res = sum;
    @(negedge clk);
    chk(done === 1'b0, "R8 done pulse", {4'b0, done}, 0);
    chk(sum === res, "R7 hold", sum, res);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(sum === '0 && busy === 1'b0 && done === 1'b0, "R1 reset", sum, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sum === '0, "R1 after release", sum, 0);
    run_add('0, '0, 0);
    run_add('1, '1, 0);
    run_add('1, W'(1), 0);
    run_add('0, '1, 0);
    run_add(W'(5), W'(10), 1);
    for (int i = 0; i < 40; i++)
      run_add(W'($urandom), W'($urandom), ($urandom % 4) == 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule